// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block guards a processor against running away. Software programs an 8-bit control register to pick a timeout length, the action taken on expiry and whether escalation is allowed. It then has to prove it is alive by writing a two-byte key to a separate 8-bit service register. The counter advances on a prescaled tick input and restarts only when the key arrives in the right order. If the key never arrives, the counter expires and the block either raises an interrupt or pulses a system reset request. A reset caused this way sets a sticky cause flag.

In interrupt mode, the first expiry leaves a timeout pending, and the control register is frozen until an interrupt-acknowledge pulse arrives. If escalation is enabled and a further full timeout passes with no acknowledge, the block emits a one-cycle strobe that ends the stalled bus cycle. It also records that the strobe was sent. The tick prescaler sits outside this block.

The register bus is a single-cycle write strobe with one select line. Select 0 addresses the control register and select 1 addresses the service register. Read data for the selected register appears combinationally. The asynchronous reset input is released through a two-stage synchronizer inside the block.

Top module: `svc_watchdog`

## Requirements
- R1: After reset the control register reads 0x00, and the interrupt, reset-request, strobe and cause outputs are all low. No expiry occurs while the enable bit is 0.
- R2: Select 0 addresses the control register, which reads back at any time with this bit layout: [7] enable, [6] action select (1 = reset, 0 = interrupt), [5:3] period select, [2] escalation enable, [1] strobe-sent flag, [0] interrupt flag. Writing 1 to bit 1 or bit 0 clears that flag, and a write never sets either flag. Select 1 reads 0x00.
- R3: The counter restarts only when 0x55 is written to the service register and 0xAA is written there later. Any other bus accesses may come in between, and a repeated 0x55 keeps the key armed. A lone 0xAA, or any other service value, neither restarts the counter nor disarms the key.
- R4: With the enable bit at 1, the counter advances once per clock in which the tick input is high. Expiry happens on the 2^(9+2·P)-th counted tick after a restart, where P is the period select.
- R5: On expiry with action select 1, the reset-request output pulses for exactly one clock. On expiry with action select 0, the interrupt flag is set and drives the interrupt output high.
- R6: The reset-cause output is set by a reset-mode expiry and stays high until the reset input is asserted.
- R7: While an interrupt-mode timeout is pending with escalation enabled, each further expiry pulses the strobe output for one clock and sets the strobe-sent flag. With escalation disabled, no strobe is produced.
- R8: While a timeout is pending, every write to the control register is ignored, including writes to the flag bits.
- R9: An interrupt-acknowledge pulse clears the pending state, which unlocks the control register, and restarts the counter.
- R10: The key sequence restarts the counter even while the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled count enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sel_i | input | 1 | Register select: 0 = control, 1 = service |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register |
| irq_ack_i | input | 1 | Interrupt-acknowledge pulse |
| wdt_irq_o | output | 1 | Watchdog interrupt (the interrupt flag) |
| wdt_rst_req_o | output | 1 | One-cycle system reset request |
| bus_term_o | output | 1 | One-cycle bus-cycle terminate strobe |
| rst_cause_o | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
The embedded properties watch the local invariants on every cycle. The counter holds while disabled and not restarted, and it returns to zero after a restart or an expiry. Specific service bytes arm the key, and other bytes leave it unchanged. The configuration stays frozen under a locked write, a strobe is always matched by its flag, the reset request lasts one cycle, and the cause bit is sticky. Only the directed scenarios can show the cycle-exact timeout length for different periods and tick gaps. They also show that a restart really moves the next expiry, that the strobe waits a full second timeout, and that acknowledge-then-clear sequences leave the register values software expects.

// File: rtl/svc_wdt_pkg.sv
package svc_wdt_pkg;

  localparam int REG_W = 8;
  localparam int PER_W = 3;

  localparam logic [REG_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [REG_W-1:0] KEY_FIRE = 8'hAA;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_SVC  = 1'b1;

  // Field order sets the bit positions software decodes (MSB first).
  typedef struct packed {
    logic             en;
    logic             rst_sel;
    logic [PER_W-1:0] period;
    logic             esc_en;
    logic             esc_seen;
    logic             irq_flag;
  } wdt_ctrl_t;

endpackage

// File: rtl/svc_wdt_keyseq.sv
module svc_wdt_keyseq
  import svc_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             svc_wr_i,
  input  logic [REG_W-1:0] svc_data_i,
  output logic             restart_o
);

  logic armed_q, armed_d;
  logic is_arm, is_fire;

  assign is_arm  = svc_wr_i && (svc_data_i == KEY_ARM);
  assign is_fire = svc_wr_i && (svc_data_i == KEY_FIRE);

  always_comb begin
    armed_d = armed_q;
    if (is_arm)       armed_d = 1'b1;
    else if (is_fire) armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  assign restart_o = is_fire && armed_q;

  // R3: first key arms the sequence
  assert_key_arms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_arm |=> armed_q);

  // R3: a completed sequence leaves the key disarmed
  assert_fire_disarms_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !armed_q);

  // R3: unrelated service values leave the key state alone
  assert_junk_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_wr_i && !is_arm && !is_fire) |=> $stable(armed_q));

endmodule

// File: rtl/svc_wdt_counter.sv
module svc_wdt_counter #(
  parameter int PER_W     = 3,
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [PER_W-1:0] period_i,
  output logic             expire_o
);

  localparam int NPER  = 1 << PER_W;
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NPER - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term_tab [NPER];
  logic             at_term;
  logic             step;

  for (genvar g = 0; g < NPER; g++) begin : g_term
    localparam int SH = CNT_W - BASE_LOG2 - STEP_LOG2 * g;
    assign term_tab[g] = {CNT_W{1'b1}} >> SH;
  end

  assign step     = tick_i && en_i;
  assign at_term  = (cnt_q >= term_tab[period_i]);
  assign expire_o = step && at_term && !restart_i;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)    cnt_d = '0;
    else if (step) begin
      if (at_term)    cnt_d = '0;
      else            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R4: a disabled counter holds unless the key restarts it
  assert_hold_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i) |=> $stable(cnt_q));

  // R3: a restart always returns the count to zero
  assert_restart_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));

  // R4: expiry wraps the count for the next period
  assert_expire_wraps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/svc_wdt_ctrl.sv
module svc_wdt_ctrl
  import svc_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             expire_i,
  input  logic             ack_i,
  output wdt_ctrl_t        ctrl_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             term_o,
  output logic             cause_o
);

  wdt_ctrl_t ctrl_q, ctrl_d, wr_view;
  logic      pend_q, pend_d;
  logic      rreq_q, rreq_d;
  logic      term_q, term_d;
  logic      cause_q, cause_d;

  assign wr_view = wdt_ctrl_t'(wdata_i);

  always_comb begin
    ctrl_d  = ctrl_q;
    pend_d  = pend_q;
    rreq_d  = 1'b0;
    term_d  = 1'b0;
    cause_d = cause_q;

    if (ctl_wr_i && !pend_q) begin
      ctrl_d.en      = wr_view.en;
      ctrl_d.rst_sel = wr_view.rst_sel;
      ctrl_d.period  = wr_view.period;
      ctrl_d.esc_en  = wr_view.esc_en;
      if (wr_view.esc_seen) ctrl_d.esc_seen = 1'b0;
      if (wr_view.irq_flag) ctrl_d.irq_flag = 1'b0;
    end

    if (ack_i) pend_d = 1'b0;

    if (expire_i) begin
      if (pend_q) begin
        if (ctrl_q.esc_en) begin
          term_d          = 1'b1;
          ctrl_d.esc_seen = 1'b1;
        end
      end else if (ctrl_q.rst_sel) begin
        rreq_d  = 1'b1;
        cause_d = 1'b1;
      end else begin
        ctrl_d.irq_flag = 1'b1;
        pend_d          = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      pend_q  <= 1'b0;
      rreq_q  <= 1'b0;
      term_q  <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      pend_q  <= pend_d;
      rreq_q  <= rreq_d;
      term_q  <= term_d;
      cause_q <= cause_d;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign irq_o     = ctrl_q.irq_flag;
  assign rst_req_o = rreq_q;
  assign term_o    = term_q;
  assign cause_o   = cause_q;

  // R8: configuration frozen under a locked write
  assert_locked_cfg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && pend_q && !expire_i) |=> $stable(ctrl_q));

  // R7: every strobe is recorded in the status flag
  assert_strobe_flagged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_q |-> ctrl_q.esc_seen);

  // R5: reset request is a single-cycle pulse
  assert_rreq_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rreq_q |=> !rreq_q);

  // R5: reset-mode expiry requests a reset and raises no interrupt
  assert_rst_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !pend_q && ctrl_q.rst_sel) |=> (rreq_q && !$rose(ctrl_q.irq_flag)));

  // R6: the cause flag never falls outside reset
  assert_cause_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_q |=> cause_q);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bus_wr_i,
  input  logic             bus_sel_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             irq_ack_i,
  output logic             wdt_irq_o,
  output logic             wdt_rst_req_o,
  output logic             bus_term_o,
  output logic             rst_cause_o
);

  logic [1:0] rsync_q;
  logic       rst_n;
  logic       key_restart;
  logic       restart;
  logic       expire;
  logic       ctl_wr;
  logic       svc_wr;
  wdt_ctrl_t  ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  assign ctl_wr  = bus_wr_i && (bus_sel_i == SEL_CTRL);
  assign svc_wr  = bus_wr_i && (bus_sel_i == SEL_SVC);
  assign restart = key_restart || irq_ack_i;

  svc_wdt_keyseq u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .svc_wr_i   (svc_wr),
    .svc_data_i (bus_wdata_i),
    .restart_o  (key_restart)
  );

  svc_wdt_counter #(
    .PER_W     (PER_W),
    .BASE_LOG2 (9),
    .STEP_LOG2 (2)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (tick_i),
    .en_i      (ctrl.en),
    .restart_i (restart),
    .period_i  (ctrl.period),
    .expire_o  (expire)
  );

  svc_wdt_ctrl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .ctl_wr_i  (ctl_wr),
    .wdata_i   (bus_wdata_i),
    .expire_i  (expire),
    .ack_i     (irq_ack_i),
    .ctrl_o    (ctrl),
    .irq_o     (wdt_irq_o),
    .rst_req_o (wdt_rst_req_o),
    .term_o    (bus_term_o),
    .cause_o   (rst_cause_o)
  );

  assign bus_rdata_o = (bus_sel_i == SEL_SVC) ? '0 : REG_W'(ctrl);

  // R5: a reset request and a bus strobe never coincide
  assert_one_action_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wdt_rst_req_o && bus_term_o));

endmodule

// File: tb/sim_svc_watchdog.sv
module sim_svc_watchdog;

  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, tick, wr, sel, ack;
  logic [7:0] wdata, rdata;
  logic       irq, rreq, term, cause;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 0;

  svc_watchdog u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_i        (tick),
    .bus_wr_i      (wr),
    .bus_sel_i     (sel),
    .bus_wdata_i   (wdata),
    .bus_rdata_o   (rdata),
    .irq_ack_i     (ack),
    .wdt_irq_o     (irq),
    .wdt_rst_req_o (rreq),
    .bus_term_o    (term),
    .rst_cause_o   (cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All helpers start and end just after a falling edge.
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic s, input logic [7:0] d);
    sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; sel = 1'b0; wdata = 8'h00;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic rd_ctrl(output logic [7:0] v);
    sel = 1'b0;
    #1 v = rdata;
  endtask

  task automatic cleanup();
    pulse_ack();
    bus_wr(1'b0, 8'h03);
    bus_wr(1'b1, 8'h55);
    bus_wr(1'b1, 8'hAA);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_ctrl(v);
    chk("R1 ctrl after reset", v, 8'h00);
    chk("R1 irq after reset", irq, 0);
    chk("R1 rreq after reset", rreq, 0);
    chk("R1 term after reset", term, 0);
    chk("R1 cause after reset", cause, 0);
    wait_cyc(600);
    chk("R1 no expiry while disabled", irq, 0);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    bus_wr(1'b0, 8'h2C);
    rd_ctrl(v);
    chk("R2 config readback", v, 8'h2C);
    bus_wr(1'b0, 8'h2F);
    rd_ctrl(v);
    chk("R2 flags not set by write", v, 8'h2C);
    sel = 1'b1;
    #1 chk("R2 service reads zero", rdata, 8'h00);
    sel = 1'b0;
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_irq_lock_ack();
    logic [7:0] v;
    bus_wr(1'b0, 8'h80);
    wait_cyc(511);
    chk("R4 no irq one tick early", irq, 0);
    wait_cyc(1);
    chk("R5 irq at 512 ticks", irq, 1);
    rd_ctrl(v);
    chk("R2 irq flag in ctrl", v, 8'h81);
    bus_wr(1'b0, 8'h00);
    bus_wr(1'b0, 8'h01);
    rd_ctrl(v);
    chk("R8 locked writes ignored", v, 8'h81);
    chk("R8 irq held while locked", irq, 1);
    wait_cyc(150);
    pulse_ack();
    bus_wr(1'b0, 8'h81);
    rd_ctrl(v);
    chk("R9 unlocked, flag cleared by W1C", v, 8'h80);
    wait_cyc(510);
    chk("R9 ack restarted counter", irq, 0);
    wait_cyc(1);
    chk("R9 expiry 512 after ack", irq, 1);
    cleanup();
  endtask

  task automatic t_key_negative();
    bus_wr(1'b0, 8'h80);
    wait_cyc(99);
    bus_wr(1'b1, 8'hAA);
    bus_wr(1'b1, 8'h12);
    wait_cyc(410);
    chk("R3 lone AA no restart (before)", irq, 0);
    wait_cyc(1);
    chk("R3 lone AA no restart (expiry)", irq, 1);
    cleanup();
  endtask

  task automatic t_key_positive();
    bus_wr(1'b0, 8'h80);
    wait_cyc(299);
    bus_wr(1'b1, 8'h55);
    bus_wr(1'b0, 8'h80);
    bus_wr(1'b1, 8'h55);
    bus_wr(1'b1, 8'h33);
    bus_wr(1'b1, 8'hAA);
    wait_cyc(511);
    chk("R3 key restarted counter", irq, 0);
    wait_cyc(1);
    chk("R3 expiry 512 after key", irq, 1);
    cleanup();
  endtask

  task automatic t_key_disabled();
    bus_wr(1'b0, 8'h80);
    wait_cyc(299);
    bus_wr(1'b0, 8'h00);
    wait_cyc(50);
    chk("R4 no expiry while disabled", irq, 0);
    bus_wr(1'b1, 8'h55);
    bus_wr(1'b1, 8'hAA);
    bus_wr(1'b0, 8'h80);
    wait_cyc(511);
    chk("R10 key cleared disabled counter", irq, 0);
    wait_cyc(1);
    chk("R10 full period after enable", irq, 1);
    cleanup();
  endtask

  task automatic t_tick_period();
    bus_wr(1'b0, 8'h80);
    wait_cyc(199);
    tick = 1'b0;
    wait_cyc(100);
    tick = 1'b1;
    wait_cyc(312);
    chk("R4 gap in ticks delays expiry", irq, 0);
    wait_cyc(1);
    chk("R4 expiry after 512 counted ticks", irq, 1);
    cleanup();
    bus_wr(1'b0, 8'h88);
    wait_cyc(2047);
    chk("R4 period 1 not early", irq, 0);
    wait_cyc(1);
    chk("R4 period 1 expires at 2048", irq, 1);
    cleanup();
  endtask

  task automatic t_reset_mode();
    logic [7:0] v;
    bus_wr(1'b0, 8'hC0);
    wait_cyc(511);
    chk("R5 no reset request early", rreq, 0);
    wait_cyc(1);
    chk("R5 reset request at expiry", rreq, 1);
    chk("R6 cause set", cause, 1);
    chk("R5 no irq in reset mode", irq, 0);
    wait_cyc(1);
    chk("R5 reset request one cycle", rreq, 0);
    rd_ctrl(v);
    chk("R5 ctrl unchanged by reset expiry", v, 8'hC0);
    cleanup();
    wait_cyc(20);
    chk("R6 cause sticky", cause, 1);
  endtask

  task automatic t_escalate();
    logic [7:0] v;
    bus_wr(1'b0, 8'h84);
    wait_cyc(512);
    chk("R5 irq before escalation", irq, 1);
    chk("R7 no strobe on first expiry", term, 0);
    wait_cyc(511);
    chk("R7 no strobe before second timeout", term, 0);
    wait_cyc(1);
    chk("R7 strobe on second timeout", term, 1);
    rd_ctrl(v);
    chk("R7 strobe-sent flag", v, 8'h87);
    wait_cyc(1);
    chk("R7 strobe one cycle", term, 0);
    cleanup();
    rd_ctrl(v);
    chk("R2 W1C clears both flags", v, 8'h00);
  endtask

  task automatic t_no_escalate();
    logic [7:0] v;
    int seen = 0;
    bus_wr(1'b0, 8'h80);
    wait_cyc(512);
    chk("R5 irq without escalation", irq, 1);
    for (int i = 0; i < 520; i++) begin
      @(negedge clk);
      if (term) seen++;
    end
    chk("R7 no strobe when disabled", 8'(seen), 8'h00);
    rd_ctrl(v);
    chk("R7 strobe flag stays clear", v, 8'h81);
    cleanup();
  endtask

  task automatic t_final_reset();
    rst_n = 1'b0;
    #1 chk("R6 cause cleared by reset", cause, 0);
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R1 irq low after reset", irq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; wr = 1'b0; sel = 1'b0; wdata = 8'h00; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_readback();
    t_irq_lock_ack();
    t_key_negative();
    t_key_positive();
    t_key_disabled();
    t_tick_period();
    t_reset_mode();
    t_escalate();
    t_no_escalate();
    t_final_reset();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule